// File: doc/BRIEF.md
# Limp-Mode Clock Source Controller

This block decides whether the chip runs from its normal PLL or oscillator clock or from an always-running backup ring-oscillator clock. It watches a reference clock for loss of activity and keeps a live loss flag and a sticky loss flag. It takes software control bits for the enable and the forced switch, and it observes the chip hard-reset state. It drives a source-select line to an external glitch-free clock mux. The mux itself is not part of this block.

Every change of source made under software or fault control starts a fixed-length hard-reset request pulse. While hard reset is already active, the selection follows PLL validity and no request is issued. All logic runs in the backup-clock domain. The PLL-valid, reference and hard-reset inputs are asynchronous and each passes through a two-flop synchronizer. The software bits come from a register in the same domain and are used directly.

Top module: `limp_clk_ctrl`

## Requirements
- R1: `loss_now` goes to 1 once `TIMEOUT` backup cycles pass with no edge of the synchronized reference. It returns to 0 within a few cycles after reference edges resume.
- R2: `loss_seen` is set whenever `loss_now` is 1, and also while hard reset is active with the PLL invalid. A one-cycle `clr_sticky` clears it only when neither set condition holds. While `loss_now` is 1, `clr_sticky` has no effect.
- R3: With `limp_en`=1 and the main source selected, `loss_now`=1 moves the selection to backup (`sel_backup`=1).
- R4: With `limp_en`=1 and the main source selected, `to_backup`=1 moves the selection to backup.
- R5: With backup selected and `limp_en`=1, the selection returns to main once `to_backup`=0 and `loss_seen`=0. The return takes effect on the cycle after the last of these two conditions becomes true.
- R6: With `limp_en`=0, neither `to_backup` nor `loss_now` moves the selection from main to backup outside hard reset.
- R7: With backup selected, clearing `limp_en` returns the selection to main.
- R8: While hard reset is active, the selection is set as follows. A rising edge of hard reset with the PLL valid selects main. A PLL that is invalid at any point during hard reset selects backup. No request pulse is issued for these changes.
- R9: After hard reset is released, PLL validity has no effect on the selection.
- R10: Each change of selection outside hard reset makes `hrst_req` high in the same cycle that `sel_backup` changes. The request stays high for exactly `PULSE_LEN` cycles. A new change restarts this count.
- R11: After reset, `sel_backup`, `loss_now`, `loss_seen` and `hrst_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backup ring-oscillator clock, always running |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pll_ok_a | input | 1 | PLL output valid and locked (asynchronous) |
| ref_a | input | 1 | Reference clock watched for activity (asynchronous) |
| hrst_a | input | 1 | Chip hard reset active (asynchronous) |
| limp_en | input | 1 | Enables switching to the backup clock |
| to_backup | input | 1 | Software request to run from the backup clock |
| clr_sticky | input | 1 | One-cycle write-to-clear of the sticky loss flag |
| sel_backup | output | 1 | 1 selects the backup clock, 0 selects the main clock |
| loss_now | output | 1 | Live loss-of-clock flag |
| loss_seen | output | 1 | Sticky loss-of-clock flag |
| hrst_req | output | 1 | Hard-reset request pulse |

## Verification
The software bits act on the first clock edge: `sel_backup` and `hrst_req` change one cycle after `limp_en` or `to_backup` is driven. A `clr_sticky` pulse clears `loss_seen` after one edge, and the selection follows one edge later. The asynchronous inputs pass two synchronizer flops before the state register, so their results are due three edges after the pin changes. The bench therefore waits four or more cycles after driving them. Loss detection takes the synchronizer delay plus `TIMEOUT` cycles. All inputs are driven and all outputs sampled on the falling edge. In the random phase, a bench model with its own pulse counter predicts `sel_backup` and `hrst_req` for every cycle.

// File: rtl/limp_clk_pkg.sv
// Shared types for the limp-mode clock source controller.
package limp_clk_pkg;
    // Clock source selection; the encoding is the value of sel_backup.
    typedef enum logic {
        SRC_MAIN   = 1'b0,
        SRC_BACKUP = 1'b1
    } src_e;
endpackage

// File: rtl/limp_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level that is stable far longer than one clock.
module limp_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit; reset clears both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/limp_loss_det.sv
// Loss-of-clock detector. It counts backup-clock cycles since the last
// edge of an already synchronized reference and flags a loss once the
// count reaches TIMEOUT. Assumes the reference is much slower than clk.
module limp_loss_det #(
    parameter int TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    output logic loss
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic          ref_d;
    logic [CW-1:0] idle_cnt;
    logic          ref_edge;

    assign ref_edge = ref_s ^ ref_d;

    // Delayed copy of the reference, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d <= 1'b0;
        else        ref_d <= ref_s;
    end

    // Idle counter: cleared by any reference edge, saturates at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                idle_cnt <= '0;
        else if (ref_edge)         idle_cnt <= '0;
        else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end

    assign loss = (idle_cnt == LIMIT);
endmodule

// File: rtl/limp_rst_pulse.sv
// Fixed-length hard-reset request generator. A start strobe loads the
// counter, so the request is high for LEN cycles beginning in the cycle
// after the strobe. A new strobe restarts the count.
module limp_rst_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic req
);
    localparam int PW = $clog2(LEN + 1);

    logic [PW-1:0] left;

    // Down-counter of remaining request cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         left <= '0;
        else if (start)     left <= PW'(LEN);
        else if (left != 0) left <= left - 1'b1;
    end

    assign req = (left != '0);
endmodule

// File: rtl/limp_clk_ctrl.sv
// Limp-mode clock source controller (top). It selects the main or the
// backup clock source, keeps live and sticky loss flags, and requests a
// hard reset on every source change made outside hard reset. It runs
// entirely on the backup clock, which is assumed always running.
module limp_clk_ctrl
    import limp_clk_pkg::*;
#(
    parameter int TIMEOUT   = 8,
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_ok_a,
    input  logic ref_a,
    input  logic hrst_a,
    input  logic limp_en,
    input  logic to_backup,
    input  logic clr_sticky,
    output logic sel_backup,
    output logic loss_now,
    output logic loss_seen,
    output logic hrst_req
);
    logic pll_ok_s, ref_s, hrst_s, hrst_d;
    src_e src_q, src_d;
    logic go;

    limp_sync2 #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pll_ok_a, ref_a, hrst_a}),
        .q     ({pll_ok_s, ref_s, hrst_s})
    );

    limp_loss_det #(.TIMEOUT(TIMEOUT)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_s (ref_s),
        .loss  (loss_now)
    );

    limp_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .req   (hrst_req)
    );

    // Delayed hard-reset level, used to spot its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) hrst_d <= 1'b0;
        else        hrst_d <= hrst_s;
    end

    // Next-source decision; go marks a change that needs a reset request.
    always_comb begin
        src_d = src_q;
        go    = 1'b0;
        if (hrst_s) begin
            if (!pll_ok_s)    src_d = SRC_BACKUP;
            else if (!hrst_d) src_d = SRC_MAIN;
        end else if (src_q == SRC_MAIN) begin
            if (limp_en && (loss_now || to_backup)) begin
                src_d = SRC_BACKUP;
                go    = 1'b1;
            end
        end else if (!limp_en || (!to_backup && !loss_seen)) begin
            src_d = SRC_MAIN;
            go    = 1'b1;
        end
    end

    // Source state register.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= SRC_MAIN;
        else        src_q <= src_d;
    end

    // Sticky loss flag: setting wins over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                             loss_seen <= 1'b0;
        else if (loss_now || (hrst_s && !pll_ok_s)) loss_seen <= 1'b1;
        else if (clr_sticky)                    loss_seen <= 1'b0;
    end

    assign sel_backup = (src_q == SRC_BACKUP);
endmodule

// File: rtl/limp_clk_ctrl_chk.sv
// Property checker for limp_clk_ctrl, attached by bind. It observes the
// ports and the synchronized hard-reset and PLL levels.
module limp_clk_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hrst_s,
    input logic pll_ok_s,
    input logic limp_en,
    input logic clr_sticky,
    input logic sel_backup,
    input logic loss_now,
    input logic loss_seen,
    input logic hrst_req
);
    // R2: a live loss always leaves the sticky flag set.
    a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        loss_now |=> loss_seen);

    // R2: a clear while the loss is live does not take effect.
    a_r2_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_now && clr_sticky) |=> loss_seen);

    // R6: with the enable clear and no hard reset, main stays selected.
    a_r6_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (!hrst_s && !limp_en && !sel_backup) |=> !sel_backup);

    // R8: an invalid PLL during hard reset selects the backup clock.
    a_r8_invalid_pll: assert property (@(posedge clk) disable iff (!rst_n)
        (hrst_s && !pll_ok_s) |=> sel_backup);

    // R10: a change outside hard reset comes with the reset request.
    a_r10_req_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_backup != $past(sel_backup)) && !$past(hrst_s)) |-> hrst_req);

    // R8: a change made during hard reset starts no request.
    a_r8_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_backup != $past(sel_backup)) && $past(hrst_s) && !$past(hrst_req))
        |-> !hrst_req);
endmodule

bind limp_clk_ctrl limp_clk_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hrst_s     (hrst_s),
    .pll_ok_s   (pll_ok_s),
    .limp_en    (limp_en),
    .clr_sticky (clr_sticky),
    .sel_backup (sel_backup),
    .loss_now   (loss_now),
    .loss_seen  (loss_seen),
    .hrst_req   (hrst_req)
);

// File: tb/tb_limp_clk_ctrl.sv
`timescale 1ns/1ps
module tb_limp_clk_ctrl;
    localparam int TIMEOUT   = 8;
    localparam int PULSE_LEN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_ok_a = 1'b1, ref_a = 1'b0, hrst_a = 1'b0;
    logic limp_en = 1'b0, to_backup = 1'b0, clr_sticky = 1'b0;
    logic sel_backup, loss_now, loss_seen, hrst_req;
    logic ref_run = 1'b1;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    // Reference clock stimulus: toggles every falling edge while running.
    always @(negedge clk) if (ref_run) ref_a <= ~ref_a;

    limp_clk_ctrl #(.TIMEOUT(TIMEOUT), .PULSE_LEN(PULSE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .pll_ok_a(pll_ok_a), .ref_a(ref_a),
        .hrst_a(hrst_a), .limp_en(limp_en), .to_backup(to_backup),
        .clr_sticky(clr_sticky), .sel_backup(sel_backup),
        .loss_now(loss_now), .loss_seen(loss_seen), .hrst_req(hrst_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected pulse counter step of the bench model.
    function automatic int pulse_next(input int cnt, input bit start);
        if (start) return PULSE_LEN;
        return (cnt > 0) ? cnt - 1 : 0;
    endfunction

    // Counts request cycles from now until it drops.
    task automatic pulse_len(output int len);
        len = 0;
        for (int i = 0; i < 4 * PULSE_LEN && hrst_req; i++) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        int m_cnt;
        bit m_sel, go, le, tb;
        int len;
        void'($urandom(32'd1357));
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        // R11 reset state
        check("R11 sel", sel_backup, 0);
        check("R11 loss_now", loss_now, 0);
        check("R11 loss_seen", loss_seen, 0);
        check("R11 req", hrst_req, 0);

        // Random phase: PLL valid, reference running, no hard reset (R4 R5 R6 R7 R10)
        m_sel = 0; m_cnt = 0;
        for (int i = 0; i < 300; i++) begin
            le = $urandom_range(0, 3) != 0;
            tb = $urandom_range(0, 1);
            limp_en = le; to_backup = tb;
            go = 0;
            if (!m_sel && le && tb) begin m_sel = 1; go = 1; end
            else if (m_sel && (!le || !tb)) begin m_sel = 0; go = 1; end
            m_cnt = pulse_next(m_cnt, go);
            @(negedge clk);
            check("R4/R5/R6/R7 random sel", sel_backup, m_sel);
            check("R10 random req", hrst_req, m_cnt != 0);
        end
        limp_en = 0; to_backup = 0;
        cyc(PULSE_LEN + 4);

        // R6: forced switch ignored while disabled
        to_backup = 1; cyc(4);
        check("R6 sel", sel_backup, 0);
        check("R6 req", hrst_req, 0);

        // R4 and R10: forced switch with enable; exact pulse length
        limp_en = 1; cyc(1);
        check("R4 sel", sel_backup, 1);
        pulse_len(len);
        check("R10 pulse length", len, PULSE_LEN);

        // R5: release of the forced switch returns to main
        to_backup = 0; cyc(1);
        check("R5 sel", sel_backup, 0);
        check("R10 req on return", hrst_req, 1);
        cyc(PULSE_LEN + 2);

        // R7: clearing enable leaves limp mode
        to_backup = 1; cyc(PULSE_LEN + 3);
        check("R7 pre sel", sel_backup, 1);
        limp_en = 0; cyc(1);
        check("R7 sel", sel_backup, 0);
        check("R7 req", hrst_req, 1);
        to_backup = 0; limp_en = 1; cyc(PULSE_LEN + 2);

        // R1 R3: reference stops
        ref_run = 0; cyc(TIMEOUT + 8);
        check("R1 loss_now", loss_now, 1);
        check("R2 sticky set", loss_seen, 1);
        check("R3 sel", sel_backup, 1);
        cyc(PULSE_LEN + 2);
        clr_sticky = 1; cyc(1); clr_sticky = 0;
        check("R2 clear blocked while live", loss_seen, 1);
        ref_run = 1; cyc(5);
        check("R1 loss clears", loss_now, 0);
        check("R5 held by sticky", sel_backup, 1);
        clr_sticky = 1; cyc(1); clr_sticky = 0;
        check("R2 clear", loss_seen, 0);
        cyc(1);
        check("R5 return after clear", sel_backup, 0);
        cyc(PULSE_LEN + 2);

        // R8: hard reset with invalid PLL
        pll_ok_a = 0; hrst_a = 1; cyc(5);
        check("R8 invalid sel", sel_backup, 1);
        check("R8 sticky", loss_seen, 1);
        check("R8 no req", hrst_req, 0);
        pll_ok_a = 1; hrst_a = 0; cyc(5);
        check("R8 held after release", sel_backup, 1);
        clr_sticky = 1; cyc(1); clr_sticky = 0; cyc(1);
        check("R5 back to main", sel_backup, 0);
        cyc(PULSE_LEN + 2);

        // R9: PLL drop outside hard reset
        pll_ok_a = 0; cyc(6);
        check("R9 sel", sel_backup, 0);
        check("R9 sticky", loss_seen, 0);
        pll_ok_a = 1;

        // R8: hard reset rise with valid PLL selects main, later PLL loss selects backup
        to_backup = 1; cyc(PULSE_LEN + 3);
        check("R8 pre sel", sel_backup, 1);
        hrst_a = 1; cyc(5);
        check("R8 valid sel", sel_backup, 0);
        check("R8 valid no req", hrst_req, 0);
        pll_ok_a = 0; cyc(5);
        check("R8 lost during reset", sel_backup, 1);
        check("R8 lost no req", hrst_req, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule